// File: doc/BRIEF.md
# Link Interrupt Status and Mask

This block gathers the event pulses raised by a serial storage link into one status register. A mask register sits beside it, and the block drives a single registered interrupt line. Each event pulse sets its own status bit. The bit stays set until software acknowledges it. Acknowledgement uses a zero-to-clear write: a 0 in a written bit clears that bit, and a 1 leaves it as it was. Software can therefore acknowledge exactly the events it has handled by writing the complement of those bits. Events it has not yet seen are not lost.

A mask bit at 1 blocks its status bit from reaching the interrupt line. The combined line feeds the link-interrupt position of a higher-level controller status register, and that controller's own enable bit gates it. The block provides the gated form as a second output. The number of implemented event bits is a build-time parameter, 11 or 12. The all-masked value follows from that width.

Top module: `lnk_irq_agg`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1, and both interrupt outputs are 0.
- R2: A 1 on evt_pulse[i] at a clock edge makes stat_q[i] read 1 after that edge, and the bit holds without further events until it is cleared.
- R3: When stat_we is high at an edge, each status bit whose stat_wdata bit is 0 becomes 0, and each bit whose stat_wdata bit is 1 keeps its value.
- R4: If evt_pulse[i] is 1 in the same cycle as a write with stat_wdata[i] = 0, the event wins and stat_q[i] is 1 after the edge.
- R5: When mask_we is high at an edge, mask_q takes mask_wdata; otherwise it holds. A mask bit of 1 stops its status bit from driving the interrupt. Bit 0 is the taskfile source, bit 1 critical error, bit 2 general error and bit 3 link error.
- R6: link_irq is registered. After each edge it equals the OR over all i of (stat_q[i] AND NOT mask_q[i]) as those registers stood before that edge, so it lags the status and mask registers by one cycle.
- R7: host_irq equals link_irq ANDed with host_irq_en, combinationally.
- R8: NUM_EVT is 11 or 12. The reset mask is all ones over that width (0x7FF or 0xFFF), and the top event bit NUM_EVT-1 sets, masks and interrupts like any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | NUM_EVT | Event pulses from the link, one per status bit |
| stat_we | input | 1 | Status acknowledge write strobe |
| stat_wdata | input | NUM_EVT | Acknowledge data; 0 clears, 1 keeps |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NUM_EVT | New mask value; 1 blocks a source |
| host_irq_en | input | 1 | Higher-level enable for the link interrupt |
| stat_q | output | NUM_EVT | Status register |
| mask_q | output | NUM_EVT | Mask register |
| link_irq | output | 1 | Registered combined interrupt |
| host_irq | output | 1 | link_irq gated by host_irq_en |

## Verification
The first pattern is an event on a fully masked source. It shows that latching and signalling are separate, because the status bit sets while the line stays low. Unmasking that bit then shows the one-cycle register lag, since the line is still low right after the mask write and rises one cycle later. An acknowledge that clears one of several pending bits separates per-bit clearing from a whole-register clear. An acknowledge that lands on the same bit as a new event separates event priority from write priority. Events on bit 0 and on the top bit, NUM_EVT-1, check both ends of the vector.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;
    // Bit positions with fixed meaning, shared by status and mask.
    localparam int unsigned SRC_TASKFILE = 0;
    localparam int unsigned SRC_CRIT_ERR = 1;
    localparam int unsigned SRC_GEN_ERR  = 2;
    localparam int unsigned SRC_LINK_ERR = 3;

    // Widths the block may be built with.
    localparam int unsigned WIDTH_NARROW = 11;
    localparam int unsigned WIDTH_WIDE   = 12;
endpackage

// File: rtl/lnk_irq_status.sv
module lnk_irq_status #(
    parameter int unsigned NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               stat_we,
    input  logic [NUM_EVT-1:0] stat_wdata,
    output logic [NUM_EVT-1:0] stat_q
);
    typedef struct packed {
        logic [NUM_EVT-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NUM_EVT-1:0] keep;
        st_d = st_q;
        keep = stat_we ? stat_wdata : {NUM_EVT{1'b1}};
        // A new event overrides a clearing write on the same bit.
        st_d.stat = (st_q.stat & keep) | evt_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q = st_q.stat;
endmodule

// File: rtl/lnk_irq_mask.sv
module lnk_irq_mask #(
    parameter int unsigned NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] mask_wdata,
    output logic [NUM_EVT-1:0] mask_q
);
    localparam logic [NUM_EVT-1:0] MASK_ALL = {NUM_EVT{1'b1}};

    typedef struct packed {
        logic [NUM_EVT-1:0] mask;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (mask_we) begin
            mk_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q.mask <= MASK_ALL;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask_q = mk_q.mask;
endmodule

// File: rtl/lnk_irq_merge.sv
module lnk_irq_merge #(
    parameter int unsigned NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] stat_q,
    input  logic [NUM_EVT-1:0] mask_q,
    output logic               link_irq
);
    typedef struct packed {
        logic irq;
    } mg_t;

    mg_t mg_d, mg_q;
    logic [NUM_EVT-1:0] live;

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_gate
        assign live[gi] = stat_q[gi] & ~mask_q[gi];
    end

    always_comb begin
        mg_d     = mg_q;
        mg_d.irq = |live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mg_q.irq <= 1'b0;
        end else begin
            mg_q <= mg_d;
        end
    end

    assign link_irq = mg_q.irq;
endmodule

// File: rtl/lnk_irq_agg.sv
module lnk_irq_agg #(
    parameter int unsigned NUM_EVT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               stat_we,
    input  logic [NUM_EVT-1:0] stat_wdata,
    input  logic               mask_we,
    input  logic [NUM_EVT-1:0] mask_wdata,
    input  logic               host_irq_en,
    output logic [NUM_EVT-1:0] stat_q,
    output logic [NUM_EVT-1:0] mask_q,
    output logic               link_irq,
    output logic               host_irq
);
    lnk_irq_status #(.NUM_EVT(NUM_EVT)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_pulse  (evt_pulse),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .stat_q     (stat_q)
    );

    lnk_irq_mask #(.NUM_EVT(NUM_EVT)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mask_q     (mask_q)
    );

    lnk_irq_merge #(.NUM_EVT(NUM_EVT)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .link_irq (link_irq)
    );

    // The higher-level controller enable gates the combined line.
    assign host_irq = link_irq & host_irq_en;
endmodule

// File: rtl/lnk_irq_agg_chk.sv
module lnk_irq_agg_chk #(
    parameter int unsigned NUM_EVT = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               stat_we,
    input logic [NUM_EVT-1:0] stat_wdata,
    input logic               mask_we,
    input logic [NUM_EVT-1:0] mask_wdata,
    input logic               host_irq_en,
    input logic [NUM_EVT-1:0] stat_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               link_irq,
    input logic               host_irq
);
    initial begin
        a_r8_width_legal: assert (NUM_EVT == lnk_irq_pkg::WIDTH_NARROW ||
                                  NUM_EVT == lnk_irq_pkg::WIDTH_WIDE);
    end

    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> ((stat_q & ~$past(stat_wdata) & ~$past(evt_pulse)) == '0));

    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

    a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (link_irq == |($past(stat_q) & ~$past(mask_q))));

    a_r7_host_gate: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == (link_irq && host_irq_en));
endmodule

bind lnk_irq_agg lnk_irq_agg_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .host_irq_en (host_irq_en),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .link_irq    (link_irq),
    .host_irq    (host_irq)
);

// File: tb/lnk_irq_agg_tb_top.sv
`timescale 1ns/1ps
module lnk_irq_agg_tb_top;
    localparam int unsigned N = 12;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_pulse = '0;
    logic         stat_we = 1'b0;
    logic [N-1:0] stat_wdata = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         host_irq_en = 1'b0;
    logic [N-1:0] stat_q, mask_q;
    logic         link_irq, host_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lnk_irq_agg #(.NUM_EVT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .host_irq_en(host_irq_en), .stat_q(stat_q), .mask_q(mask_q),
        .link_irq(link_irq), .host_irq(host_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // One edge with the given strobes, then sample at the falling edge.
    task automatic cycle(input logic [N-1:0] ev, input logic swe, input logic [N-1:0] sd,
                         input logic mwe, input logic [N-1:0] md);
        evt_pulse = ev; stat_we = swe; stat_wdata = sd; mask_we = mwe; mask_wdata = md;
        @(posedge clk);
        @(negedge clk);
        evt_pulse = '0; stat_we = 1'b0; mask_we = 1'b0;
    endtask

    task automatic idle();
        cycle('0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_reset();
        check("R1 stat after reset", 32'(stat_q), 32'h0);
        check("R1 R8 mask after reset", 32'(mask_q), 32'hFFF);
        check("R1 link_irq after reset", 32'(link_irq), 32'h0);
        check("R1 host_irq after reset", 32'(host_irq), 32'h0);
    endtask

    task automatic t_masked_event();
        cycle(12'h008, 1'b0, '0, 1'b0, '0);          // link-error source
        check("R2 status latches", 32'(stat_q), 32'h008);
        idle();
        idle();
        check("R2 status holds", 32'(stat_q), 32'h008);
        check("R5 masked source silent", 32'(link_irq), 32'h0);
    endtask

    task automatic t_unmask();
        host_irq_en = 1'b1;
        cycle('0, 1'b0, '0, 1'b1, ALL & ~12'h008);
        check("R5 mask loads", 32'(mask_q), 32'hFF7);
        check("R6 irq lags one cycle", 32'(link_irq), 32'h0);
        idle();
        check("R6 irq after lag", 32'(link_irq), 32'h1);
        check("R7 host_irq enabled", 32'(host_irq), 32'h1);
        host_irq_en = 1'b0;
        #1;
        check("R7 host_irq gated off", 32'(host_irq), 32'h0);
        host_irq_en = 1'b1;
    endtask

    task automatic t_selective_ack();
        cycle(12'h021, 1'b0, '0, 1'b0, '0);          // bits 0 and 5
        check("R2 more events latch", 32'(stat_q), 32'h029);
        cycle('0, 1'b1, ~12'h008, 1'b0, '0);         // acknowledge bit 3 only
        check("R3 zero clears, ones keep", 32'(stat_q), 32'h021);
        idle();
        check("R5 R6 irq drops with only masked bits", 32'(link_irq), 32'h0);
    endtask

    task automatic t_race();
        cycle(12'h020, 1'b1, ~12'h021, 1'b0, '0);    // clear 0 and 5, event on 5
        check("R4 event beats clear", 32'(stat_q), 32'h020);
    endtask

    task automatic t_top_bit();
        cycle('0, 1'b1, '0, 1'b0, '0);
        check("R3 write zero clears all", 32'(stat_q), 32'h0);
        cycle(12'h800, 1'b0, '0, 1'b1, ALL & ~12'h800);
        check("R8 top bit latches", 32'(stat_q), 32'h800);
        idle();
        check("R8 top bit interrupts", 32'(link_irq), 32'h1);
        cycle('0, 1'b0, '0, 1'b1, ALL);
        check("R5 remask keeps status", 32'(stat_q), 32'h800);
        idle();
        check("R5 R6 remask silences irq", 32'(link_irq), 32'h0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_event();
        t_unmask();
        t_selective_ack();
        t_race();
        t_top_bit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule